// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block collects a set of level-sensitive peripheral request lines plus eight requests that software sets and clears, and drives one processor interrupt line. Every source carries its own 4-bit priority. The interrupt line is raised only when the best pending request has a priority strictly above the current priority. When two pending sources tie on priority, the lower source index wins.

When the processor acknowledges the interrupt, the block latches a vector that is unique to the winning source. The vector is the programmable base plus four times the source index. The block pushes the old current priority onto a 16-entry stack and makes the winner's priority the new current priority. A higher-priority request can then preempt the running handler, so service routines nest. An end-of-interrupt strobe pops the stack to restore the previous level.

Software can also write the current priority directly. Raising it temporarily blocks every request at or below that level, which protects a resource shared by several handlers.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the interrupt output is 0 and the vector is 0. The current priority, every source priority, the base and all software requests are also 0.
- R2: The register port decodes these addresses. Address 0 reads and writes the current priority. Address 1 controls the software requests. Address 2 holds the vector base. Address 3 reads back the latched vector. Address 4+k holds the 4-bit priority of source k, and reads return the value written.
- R3: A pending source can raise the interrupt only if its priority is strictly greater than the current priority.
- R4: A source whose priority is 0 is never forwarded.
- R5: When several pending sources share the highest priority, the one with the lowest index wins.
- R6: On an acknowledge that is taken, the vector output becomes base + 4 × winning index. Address 3 reads back this same value.
- R7: An acknowledge is taken when it arrives while the interrupt is high, a request wins and the stack is not full. A taken acknowledge pushes the old current priority and loads the winner's priority. The interrupt output is 0 in the cycle after any acknowledge.
- R8: A request whose priority is higher than the priority of the routine being serviced raises the interrupt again. Acknowledging it nests one level deeper.
- R9: End-of-interrupt restores the most recently pushed priority. An end-of-interrupt with an empty stack leaves the current priority unchanged.
- R10: Sources 0 to 7 are software requests. A write to address 1 sets the requests selected by wdata[7:0] and then clears the requests selected by wdata[15:8]. A read of address 1 returns the pending software requests in bits [7:0]. A software request rises as interrupt one edge after the write edge.
- R11: Peripheral line i is source 8+i. It is level-sensitive and is registered once, so the interrupt rises on the second clock edge after the line goes high.
- R12: Writing the current priority blocks every request at or below the written level, and leaves requests above it free to interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_req | input | NUM_HW | Peripheral request levels, line i is source 8+i |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| ack | input | 1 | Interrupt acknowledge strobe |
| eoi | input | 1 | End-of-interrupt strobe |
| irq | output | 1 | Processor interrupt request |
| vector | output | 32 | Latched vector of the last acknowledged source |

## Verification
The bench builds the controller with NUM_HW = 12, which gives 20 sources and a 5-bit address. With this size the bench can reach both ends of the source range: a software source at index 3 and peripheral sources up to index 16. The stack keeps its 16 entries, so two-level nesting and the empty-stack end-of-interrupt are both reachable. The tests cover the tie on equal priorities and the equal-priority blocking at the software ceiling.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_HW = 24,
  parameter int NUM_SW = 8,
  parameter int PW     = 4,
  parameter int DEPTH  = 16,
  localparam int NUM_SRC = NUM_SW + NUM_HW,
  localparam int AW      = $clog2(NUM_SRC + 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_HW-1:0] hw_req,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ack,
  input  logic              eoi,
  output logic              irq,
  output logic [31:0]       vector
);
  localparam int IDX_W = $clog2(NUM_SRC);
  localparam int SIW   = $clog2(DEPTH);
  localparam int SPW   = $clog2(DEPTH + 1);

  logic [PW-1:0]      prio_q [NUM_SRC];
  logic [PW-1:0]      stk    [DEPTH];
  logic [NUM_SW-1:0]  sw_q;
  logic [NUM_HW-1:0]  hw_q;
  logic [PW-1:0]      cur_q;
  logic [SPW-1:0]     sp;
  logic [31:0]        base_q, vec_q;
  logic               irq_q;

  logic [NUM_SRC-1:0] pend;
  logic               found, win, take, pop;
  logic [PW-1:0]      best_p;
  logic [IDX_W-1:0]   best_i;

  assign pend = {hw_q, sw_q};

  always_comb begin
    found  = 1'b0;
    best_p = '0;
    best_i = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (pend[i] && prio_q[i] != '0 && (!found || prio_q[i] > best_p)) begin
        found  = 1'b1;
        best_p = prio_q[i];
        best_i = IDX_W'(i);
      end
  end

  assign win  = found && best_p > cur_q;
  assign take = ack && irq_q && win && sp != SPW'(DEPTH);
  assign pop  = eoi && !take && sp != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_SRC; k++) prio_q[k] <= '0;
      for (int k = 0; k < DEPTH; k++) stk[k] <= '0;
      sw_q   <= '0;
      hw_q   <= '0;
      cur_q  <= '0;
      sp     <= '0;
      base_q <= '0;
      vec_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      hw_q  <= hw_req;
      irq_q <= win && !ack;
      if (take) begin
        vec_q          <= base_q + (32'(best_i) << 2);
        stk[sp[SIW-1:0]] <= cur_q;
        sp             <= sp + 1'b1;
        cur_q          <= best_p;
      end else if (pop) begin
        cur_q <= stk[SIW'(sp - 1'b1)];
        sp    <= sp - 1'b1;
      end else if (reg_we && reg_addr == AW'(0)) begin
        cur_q <= reg_wdata[PW-1:0];
      end
      if (reg_we) begin
        if (reg_addr == AW'(1))
          sw_q <= (sw_q | reg_wdata[NUM_SW-1:0]) & ~reg_wdata[2*NUM_SW-1:NUM_SW];
        if (reg_addr == AW'(2))
          base_q <= reg_wdata;
        for (int k = 0; k < NUM_SRC; k++)
          if (reg_addr == AW'(k + 4)) prio_q[k] <= reg_wdata[PW-1:0];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(0): reg_rdata = 32'(cur_q);
      AW'(1): reg_rdata = 32'(sw_q);
      AW'(2): reg_rdata = base_q;
      AW'(3): reg_rdata = vec_q;
      default:
        for (int k = 0; k < NUM_SRC; k++)
          if (reg_addr == AW'(k + 4)) reg_rdata = 32'(prio_q[k]);
    endcase
  end

  assign irq    = irq_q;
  assign vector = vec_q;

  a_r7_ack_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !irq);
  a_r7_ack_raises_level: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> cur_q > $past(cur_q));
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SPW'(DEPTH));
  a_r9_empty_eoi_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack && sp == '0 && !(reg_we && reg_addr == AW'(0))) |=> $stable(cur_q) && sp == '0);
  a_r9_pop_one_level: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> sp == $past(sp) - 1'b1);
endmodule

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;
  localparam int NHW = 12;
  localparam int AW  = $clog2(NHW + 8 + 4);
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic clk = 0, rst_n = 0, reg_we = 0, ack = 0, eoi = 0;
  logic [NHW-1:0] hw_req = '0;
  logic [AW-1:0]  reg_addr = '0;
  logic [31:0]    reg_wdata = '0, reg_rdata, vector;
  logic           irq;
  int checks = 0, fails = 0;
  bit done = 0;

  prio_irq_ctrl #(.NUM_HW(NHW)) uut (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ack(ack), .eoi(eoi), .irq(irq), .vector(vector));

  always #2.5 clk = ~clk;

  function automatic logic [31:0] vec_of(int idx);
    return BASE + 32'(idx) * 4;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    reg_we = 1; reg_addr = AW'(a); reg_wdata = d;
    tick();
    reg_we = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    reg_addr = AW'(a);
    #0.5;
    d = reg_rdata;
  endtask

  task automatic pulse_ack();
    ack = 1; tick(); ack = 0;
  endtask

  task automatic pulse_eoi();
    eoi = 1; tick(); eoi = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", 32'(irq), 0);
    chk("R1 vector", vector, 0);
    rd(0, d); chk("R1 cur prio", d, 0);
    rd(1, d); chk("R1 sw req", d, 0);
    rd(2, d); chk("R1 base", d, 0);
    rd(4 + 9, d); chk("R1 src prio", d, 0);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    wr(2, BASE);
    wr(4 + 8, 5);
    rd(4 + 8, d); chk("R2 prio readback", d, 5);
    hw_req[0] = 1;
    tick(); chk("R11 irq not yet", 32'(irq), 0);
    tick(); chk("R11 irq raised", 32'(irq), 1);
    pulse_ack();
    chk("R7 irq drops", 32'(irq), 0);
    chk("R6 vector", vector, vec_of(8));
    rd(3, d); chk("R6 vector readback", d, vec_of(8));
    rd(0, d); chk("R7 cur loaded", d, 5);
    tick(); chk("R3 equal prio blocked", 32'(irq), 0);
  endtask

  task automatic t_nest();
    logic [31:0] d;
    wr(4 + 11, 3);
    hw_req[3] = 1;
    tick(3); chk("R3 lower prio blocked", 32'(irq), 0);
    wr(4 + 10, 9);
    hw_req[2] = 1;
    tick(2); chk("R8 preempt irq", 32'(irq), 1);
    pulse_ack();
    chk("R8 nested vector", vector, vec_of(10));
    rd(0, d); chk("R8 cur nested", d, 9);
    hw_req = '0;
    tick(2);
    pulse_eoi(); rd(0, d); chk("R9 pop to 5", d, 5);
    pulse_eoi(); rd(0, d); chk("R9 pop to 0", d, 0);
    tick(2); chk("R9 idle irq", 32'(irq), 0);
    wr(0, 4);
    pulse_eoi(); rd(0, d); chk("R9 empty eoi ignored", d, 4);
    wr(0, 0);
  endtask

  task automatic t_prio0();
    hw_req[4] = 1;
    tick(3); chk("R4 prio 0 never forwarded", 32'(irq), 0);
    hw_req[4] = 0;
    tick(2);
  endtask

  task automatic t_tie();
    logic [31:0] d;
    wr(4 + 14, 7);
    wr(4 + 13, 7);
    hw_req[5] = 1; hw_req[6] = 1;
    tick(2); chk("R5 tie irq", 32'(irq), 1);
    pulse_ack();
    chk("R5 lower index wins", vector, vec_of(13));
    hw_req = '0;
    tick(2);
    pulse_eoi(); rd(0, d); chk("R5 restore", d, 0);
    tick(2);
  endtask

  task automatic t_ceiling();
    wr(0, 7);
    wr(4 + 16, 7);
    hw_req[8] = 1;
    tick(3); chk("R12 at ceiling blocked", 32'(irq), 0);
    wr(4 + 16, 8);
    tick(2); chk("R12 above ceiling passes", 32'(irq), 1);
    hw_req[8] = 0;
    tick(2); chk("R11 level drop", 32'(irq), 0);
    wr(0, 0);
  endtask

  task automatic t_sw();
    logic [31:0] d;
    wr(4 + 3, 6);
    wr(1, 32'h0000_0008);
    rd(1, d); chk("R10 sw set readback", d, 32'h08);
    tick(); chk("R10 sw irq", 32'(irq), 1);
    pulse_ack();
    chk("R10 sw vector", vector, vec_of(3));
    rd(0, d); chk("R10 sw cur", d, 6);
    wr(1, 32'h0000_0800);
    rd(1, d); chk("R10 sw clear readback", d, 0);
    pulse_eoi(); rd(0, d); chk("R9 sw restore", d, 0);
    tick(2); chk("R10 sw idle", 32'(irq), 0);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick();
    t_reset();
    t_basic();
    t_nest();
    t_prio0();
    t_tie();
    t_ceiling();
    t_sw();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(5ns * 20000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule